// File: doc/BRIEF.md
# Clock Output Mode Selector with Test Dividers

This block sits between the frequency synthesizer of a clock generator and its output pads. For each output group (CPU, PCI, SDRAM, reference, USB and IO) it chooses one of three sources. The first is the normal synthesized clock, which is passed through unchanged. The second is a fixed binary division of an external test clock. The third is a released, undriven output. The synthesizer itself is not part of the block. Its clocks arrive here as plain inputs.

The choice comes from a 2-bit mode field held in the configuration register and from the three frequency-select pins. Test mode is honoured only for one select code. When that code is not present, a test request leaves the outputs in normal operation. The test clock is the signal on the crystal input pin, and it also clocks the divider counter. A synchronous reset clears that counter, so every divided group starts from the same phase.

Top module: `clkout_mode_sel`

## Requirements
- R1: When `mode_fld[1]` is 1, every bit of `out_en` is 0 and every clock output is driven 0. `out_en` bit order is CPU=0, PCI=1, SDRAM=2, REF=3, USB=4, IO=5.
- R2: Three-state wins over the test request. With `mode_fld` = 2'b11 and `fsel` = 3'b101, the outputs are released as in R1.
- R3: In test mode (`mode_fld` = 2'b01 and `fsel` = 3'b101), every CPU, SDRAM and USB output carries bit 0 of the test divider counter. That is the test clock divided by 2, toggling on every rising test-clock edge.
- R4: In test mode, every PCI output (including the free-running and early ones) and the IO output carry bit 1 of the divider counter. That is the test clock divided by 4, changing only on edges where the divide-by-2 output was high.
- R5: In test mode, both reference outputs follow the test clock itself: high while it is high and low while it is low.
- R6: With `mode_fld` = 2'b01 and any `fsel` other than 3'b101, all outputs equal their normal inputs and all six `out_en` bits are 1.
- R7: With `mode_fld` = 2'b00, all outputs equal their normal inputs and all `out_en` bits are 1, whatever the value of `fsel`.
- R8: While `rst_n` is low at a rising test-clock edge, the divider counter is cleared. The divided outputs read 0 after that edge, and after release the first edge gives divide-by-2 = 1 and divide-by-4 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Test clock from the crystal input; clocks the dividers |
| rst_n | input | 1 | Synchronous active-low divider reset |
| mode_fld | input | 2 | Mode field: 00 normal, 01 test, 1x three-state |
| fsel | input | 3 | Frequency-select pins {sel2, sel1, sel0} |
| cpu_n | input | 4 | Normal CPU clocks |
| pci_n | input | 7 | Normal PCI clocks, free-running and early included |
| sdram_n | input | 6 | Normal SDRAM clocks |
| ref_n | input | 2 | Normal reference clocks |
| usb_n | input | 1 | Normal USB clock |
| io_n | input | 1 | Normal IO clock |
| cpu_o | output | 4 | CPU clock outputs |
| pci_o | output | 7 | PCI clock outputs |
| sdram_o | output | 6 | SDRAM clock outputs |
| ref_o | output | 2 | Reference clock outputs |
| usb_o | output | 1 | USB clock output |
| io_o | output | 1 | IO clock output |
| out_en | output | 6 | Per-group pad drive enables, 1 = driven |

## Verification
The mode decode and the output selection are combinational. A change of `mode_fld`, `fsel` or a normal input therefore appears on the outputs in the same cycle. The bench drives such changes at the falling edge and samples two nanoseconds later. Divided outputs move one step per rising test-clock edge, one register from the counter. After reset release, the bench samples 2 ns after each rising edge and compares the result with a count it keeps itself. The reference outputs follow the test clock with no register, so they are sampled at mid-high and at mid-low of the same period.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

   typedef enum logic [1:0] {
      GM_NORM = 2'd0,
      GM_TEST = 2'd1,
      GM_HIZ  = 2'd2
   } grp_mode_e;

   localparam int unsigned MODE_W = 2;
   localparam int unsigned FSEL_W = 3;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/clkmode_decode.sv
module clkmode_decode
   import clkmode_pkg::*;
#(
   parameter logic [FSEL_W-1:0] TEST_CODE = 3'b101
) (
   input  logic [MODE_W-1:0] mode_fld,
   input  logic [FSEL_W-1:0] fsel,
   output grp_mode_e         gmode
);

   logic hiz_req;
   logic tst_req;
   logic code_ok;

   assign hiz_req = mode_fld[1];
   assign tst_req = mode_fld[0];
   assign code_ok = (fsel == TEST_CODE);

   always_comb begin
      if (hiz_req) begin
         gmode = GM_HIZ;
      end else if (tst_req && code_ok) begin
         gmode = GM_TEST;
      end else begin
         gmode = GM_NORM;
      end
   end

endmodule

// File: rtl/tclk_divider.sv
module tclk_divider #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             tclk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] taps
);

   initial begin
      if (CNT_W < 1) $error("tclk_divider: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge tclk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign taps = cnt_q;

endmodule

// File: rtl/clk_out_group.sv
module clk_out_group
   import clkmode_pkg::*;
#(
   parameter int unsigned W = 1
) (
   input  grp_mode_e    gmode,
   input  logic         tst_clk,
   input  logic [W-1:0] nrm,
   output logic [W-1:0] dout,
   output logic         oe
);

   initial begin
      if (W < 1) $error("clk_out_group: W must be at least 1");
   end

   always_comb begin
      unique case (gmode)
         GM_TEST: dout = {W{tst_clk}};
         GM_HIZ:  dout = '0;
         default: dout = nrm;
      endcase
   end

   assign oe = (gmode != GM_HIZ);

endmodule

// File: rtl/clkout_mode_sel.sv
module clkout_mode_sel
   import clkmode_pkg::*;
#(
   parameter int unsigned       N_CPU     = 4,
   parameter int unsigned       N_PCI     = 7,
   parameter int unsigned       N_SDR     = 6,
   parameter int unsigned       N_REF     = 2,
   parameter int unsigned       N_USB     = 1,
   parameter int unsigned       N_IO      = 1,
   parameter int unsigned       DIV_CPU   = 1,
   parameter int unsigned       DIV_PCI   = 2,
   parameter int unsigned       DIV_SDR   = 1,
   parameter int unsigned       DIV_REF   = 0,
   parameter int unsigned       DIV_USB   = 1,
   parameter int unsigned       DIV_IO    = 2,
   parameter logic [FSEL_W-1:0] TEST_CODE = 3'b101
) (
   input  logic              tclk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_fld,
   input  logic [FSEL_W-1:0] fsel,
   input  logic [N_CPU-1:0]  cpu_n,
   input  logic [N_PCI-1:0]  pci_n,
   input  logic [N_SDR-1:0]  sdram_n,
   input  logic [N_REF-1:0]  ref_n,
   input  logic [N_USB-1:0]  usb_n,
   input  logic [N_IO-1:0]   io_n,
   output logic [N_CPU-1:0]  cpu_o,
   output logic [N_PCI-1:0]  pci_o,
   output logic [N_SDR-1:0]  sdram_o,
   output logic [N_REF-1:0]  ref_o,
   output logic [N_USB-1:0]  usb_o,
   output logic [N_IO-1:0]   io_o,
   output logic [5:0]        out_en
);

   localparam int unsigned MAX_DIV = max_of(max_of(max_of(DIV_CPU, DIV_PCI), max_of(DIV_SDR, DIV_REF)),
                                            max_of(DIV_USB, DIV_IO));
   localparam int unsigned CNT_W   = (MAX_DIV < 1) ? 1 : MAX_DIV;
   localparam int unsigned N_GRP   = 6;
   localparam int unsigned MAX_LOG2 = 8;

   initial begin
      if (MAX_DIV > MAX_LOG2) $error("clkout_mode_sel: divide exponent above %0d", MAX_LOG2);
      if (N_CPU == 0 || N_PCI == 0 || N_SDR == 0 || N_REF == 0 || N_USB == 0 || N_IO == 0)
         $error("clkout_mode_sel: every group needs at least one output");
   end

   grp_mode_e        gmode;
   logic [CNT_W-1:0] taps;
   logic [CNT_W:0]   tap_all;
   logic [N_GRP-1:0] oe_v;

   clkmode_decode #(.TEST_CODE(TEST_CODE)) u_dec (
      .mode_fld (mode_fld),
      .fsel     (fsel),
      .gmode    (gmode)
   );

   tclk_divider #(.CNT_W(CNT_W)) u_div (
      .tclk  (tclk),
      .rst_n (rst_n),
      .taps  (taps)
   );

   assign tap_all = {taps, tclk};

   clk_out_group #(.W(N_CPU)) u_cpu (
      .gmode (gmode), .tst_clk (tap_all[DIV_CPU]), .nrm (cpu_n),   .dout (cpu_o),   .oe (oe_v[0]));
   clk_out_group #(.W(N_PCI)) u_pci (
      .gmode (gmode), .tst_clk (tap_all[DIV_PCI]), .nrm (pci_n),   .dout (pci_o),   .oe (oe_v[1]));
   clk_out_group #(.W(N_SDR)) u_sdr (
      .gmode (gmode), .tst_clk (tap_all[DIV_SDR]), .nrm (sdram_n), .dout (sdram_o), .oe (oe_v[2]));
   clk_out_group #(.W(N_REF)) u_ref (
      .gmode (gmode), .tst_clk (tap_all[DIV_REF]), .nrm (ref_n),   .dout (ref_o),   .oe (oe_v[3]));
   clk_out_group #(.W(N_USB)) u_usb (
      .gmode (gmode), .tst_clk (tap_all[DIV_USB]), .nrm (usb_n),   .dout (usb_o),   .oe (oe_v[4]));
   clk_out_group #(.W(N_IO))  u_io  (
      .gmode (gmode), .tst_clk (tap_all[DIV_IO]),  .nrm (io_n),    .dout (io_o),    .oe (oe_v[5]));

   assign out_en = oe_v;

endmodule

// File: rtl/clkout_mode_chk.sv
module clkout_mode_chk #(
   parameter int unsigned N_CPU = 4,
   parameter int unsigned N_PCI = 7
) (
   input logic             tclk,
   input logic             rst_n,
   input logic [1:0]       mode_fld,
   input logic [2:0]       fsel,
   input logic [N_CPU-1:0] cpu_n,
   input logic [N_CPU-1:0] cpu_o,
   input logic [N_PCI-1:0] pci_o,
   input logic [5:0]       out_en
);

   logic tst;
   assign tst = (mode_fld == 2'b01) && (fsel == 3'b101);

   // R1 and R2: released outputs whenever the three-state bit is set
   assert_hiz_R1: assert property (@(posedge tclk) disable iff (!rst_n)
      mode_fld[1] |-> (out_en == 6'h00 && cpu_o == '0 && pci_o == '0));

   assert_hiz_over_test_R2: assert property (@(posedge tclk) disable iff (!rst_n)
      (mode_fld == 2'b11 && fsel == 3'b101) |-> (out_en == 6'h00));

   assert_div2_R3: assert property (@(posedge tclk) disable iff (!rst_n)
      (tst && $past(tst) && $past(rst_n)) |-> (cpu_o[0] != $past(cpu_o[0])));

   assert_div4_R4: assert property (@(posedge tclk) disable iff (!rst_n)
      (tst && $past(tst) && $past(rst_n)) |-> ((pci_o[0] != $past(pci_o[0])) == $past(cpu_o[0])));

   assert_badcode_R6: assert property (@(posedge tclk) disable iff (!rst_n)
      (mode_fld == 2'b01 && fsel != 3'b101) |-> (cpu_o == cpu_n && out_en == 6'h3F));

   assert_normal_R7: assert property (@(posedge tclk) disable iff (!rst_n)
      (mode_fld == 2'b00) |-> (cpu_o == cpu_n && out_en == 6'h3F));

   assert_rst_clear_R8: assert property (@(posedge tclk)
      (!rst_n) |=> (!tst || (cpu_o[0] == 1'b0 && pci_o[0] == 1'b0)));

endmodule

bind clkout_mode_sel clkout_mode_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (
   .tclk     (tclk),
   .rst_n    (rst_n),
   .mode_fld (mode_fld),
   .fsel     (fsel),
   .cpu_n    (cpu_n),
   .cpu_o    (cpu_o),
   .pci_o    (pci_o),
   .out_en   (out_en)
);

// File: tb/tb_clkout_mode_sel.sv
`timescale 1ns/1ps
module tb_clkout_mode_sel;

   logic       tclk = 1'b0;
   logic       rst_n;
   logic [1:0] mode_fld;
   logic [2:0] fsel;
   logic [3:0] cpu_n;
   logic [6:0] pci_n;
   logic [5:0] sdram_n;
   logic [1:0] ref_n;
   logic [0:0] usb_n;
   logic [0:0] io_n;
   logic [3:0] cpu_o;
   logic [6:0] pci_o;
   logic [5:0] sdram_o;
   logic [1:0] ref_o;
   logic [0:0] usb_o;
   logic [0:0] io_o;
   logic [5:0] out_en;

   int n_run  = 0;
   int n_fail = 0;

   always #4 tclk = ~tclk;

   clkout_mode_sel dut (
      .tclk (tclk), .rst_n (rst_n), .mode_fld (mode_fld), .fsel (fsel),
      .cpu_n (cpu_n), .pci_n (pci_n), .sdram_n (sdram_n), .ref_n (ref_n),
      .usb_n (usb_n), .io_n (io_n),
      .cpu_o (cpu_o), .pci_o (pci_o), .sdram_o (sdram_o), .ref_o (ref_o),
      .usb_o (usb_o), .io_o (io_o), .out_en (out_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive_nrm(input logic [31:0] pat);
      cpu_n   = pat[3:0];
      pci_n   = pat[10:4];
      sdram_n = pat[16:11];
      ref_n   = pat[18:17];
      usb_n   = pat[19];
      io_n    = pat[20];
   endtask

   task automatic chk_pass(input string req);
      chk({req, " cpu"},   32'(cpu_o),   32'(cpu_n));
      chk({req, " pci"},   32'(pci_o),   32'(pci_n));
      chk({req, " sdram"}, 32'(sdram_o), 32'(sdram_n));
      chk({req, " ref"},   32'(ref_o),   32'(ref_n));
      chk({req, " usb"},   32'(usb_o),   32'(usb_n));
      chk({req, " io"},    32'(io_o),    32'(io_n));
      chk({req, " oe"},    32'(out_en),  32'h3F);
   endtask

   task automatic chk_hiz(input string req);
      chk({req, " oe"}, 32'(out_en), 32'h00);
      chk({req, " data"}, {cpu_o, pci_o, sdram_o, ref_o, usb_o, io_o}, 32'h0);
   endtask

   // R8: counter cleared under reset, test outputs low
   task automatic t_reset;
      @(negedge tclk);
      rst_n = 1'b0; mode_fld = 2'b01; fsel = 3'b101;
      repeat (3) @(posedge tclk);
      #2;
      chk("R8 cpu in reset", 32'(cpu_o), 32'h0);
      chk("R8 pci in reset", 32'(pci_o), 32'h0);
      chk("R8 io in reset",  32'(io_o),  32'h0);
   endtask

   // R3 R4 R5 R8: divided outputs after release
   task automatic t_dividers;
      logic [1:0] cnt;
      t_reset();
      @(negedge tclk);
      rst_n = 1'b1;
      cnt = 2'd0;
      for (int i = 0; i < 9; i++) begin
         @(posedge tclk);
         cnt = cnt + 2'd1;
         #2;
         if (i == 0) begin
            chk("R8 first edge div2", 32'(cpu_o[0]), 32'h1);
            chk("R8 first edge div4", 32'(pci_o[0]), 32'h0);
         end
         chk("R3 cpu",   32'(cpu_o),   32'({4{cnt[0]}}));
         chk("R3 sdram", 32'(sdram_o), 32'({6{cnt[0]}}));
         chk("R3 usb",   32'(usb_o),   32'(cnt[0]));
         chk("R4 pci",   32'(pci_o),   32'({7{cnt[1]}}));
         chk("R4 io",    32'(io_o),    32'(cnt[1]));
         chk("R5 ref high", 32'(ref_o), 32'h3);
         chk("R3 oe", 32'(out_en), 32'h3F);
         @(negedge tclk);
         #2;
         chk("R5 ref low", 32'(ref_o), 32'h0);
      end
   endtask

   // R6: test request with a wrong select code stays normal
   task automatic t_badcode;
      for (int c = 0; c < 8; c++) begin
         if (c != 5) begin
            @(negedge tclk);
            mode_fld = 2'b01; fsel = 3'(c);
            drive_nrm(32'h0015_A5C3 ^ (32'(c) * 32'h0003_1357));
            #2;
            chk_pass("R6");
         end
      end
   endtask

   // R7: normal mode, including the test code on the pins
   task automatic t_normal;
      @(negedge tclk);
      mode_fld = 2'b00; fsel = 3'b101; drive_nrm(32'h001F_FFFF);
      #2; chk_pass("R7 code101 ones");
      @(negedge tclk);
      fsel = 3'b010; drive_nrm(32'h000A_5A5A);
      #2; chk_pass("R7 code010 pattern");
      @(negedge tclk);
      drive_nrm(32'h0);
      #2; chk_pass("R7 zeros");
   endtask

   // R1 R2: three-state and its priority
   task automatic t_hiz;
      @(negedge tclk);
      mode_fld = 2'b10; fsel = 3'b000; drive_nrm(32'h001F_FFFF);
      #2; chk_hiz("R1 mode10");
      @(negedge tclk);
      mode_fld = 2'b11; fsel = 3'b101;
      #2; chk_hiz("R2 mode11 code101");
      @(posedge tclk);
      #2; chk_hiz("R2 after edge");
   endtask

   initial begin
      rst_n = 1'b0; mode_fld = 2'b00; fsel = 3'b000; drive_nrm(32'h0);
      repeat (2) @(posedge tclk);
      @(negedge tclk);
      rst_n = 1'b1;
      #2; chk_pass("R7 after reset");
      t_normal();
      t_badcode();
      t_hiz();
      t_dividers();
      t_normal();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule